// File: doc/BRIEF.md
# Two-Wire Command Register Slave

This block is a serial slave on a two-wire bus with a clock line and an open-drain data line. It samples both lines on the system clock and detects START, repeated START and STOP. It checks the device address in the control byte and then takes a command byte. The command byte selects one of three configuration registers, or asks for a commit to non-volatile storage.

Writes follow the command with data bytes. A read sends the command, then a repeated START, then the control byte again with the read bit set, and the slave then shifts the selected register out. The register values and one-cycle write-event strobes go to a downstream commit controller, which decides when to store the settings.

Top module: `cmdreg_twi_slave`

## Requirements
- R1: The control byte is sent MSB first as 1,0,1,1,A2,A1,A0,RW. The slave acknowledges it, by pulling SDA low during the ninth SCL pulse, only when A2..A0 equal bus_q[2:0]. On a mismatch it never drives SDA and ignores the transaction until the next START or STOP.
- R2: After an acknowledged control byte with RW=0, the slave acknowledges the command byte and every data byte that follows, whatever the command value.
- R3: Command 0x01 selects DIV and 0x02 selects MUX, each 10 bits wide. Both move as two bytes, MSB first. The first byte carries value bits 9..2. The second byte carries bits 1..0 in its positions 7..6, and its bits 5..0 read as zero.
- R4: A DIV or MUX write that ends with STOP after its first data byte updates bits 9..2 only. Bits 1..0 keep their value.
- R5: Command 0x0D selects the one-byte BUS register. Any byte after its first is discarded. Its bits 2..0 become the device address for the next transaction.
- R6: Command 0x3F gives a one-cycle pulse on commit_req and changes no register. It may be sent standalone, as control byte, command byte, STOP.
- R7: Data written under any other command value is acknowledged and then discarded. A read under such a command returns 0xFF. A read past a register's last byte also returns 0xFF.
- R8: A read returns the selected register's bytes MSB first. A master ACK asks for the next byte. After a master NACK the slave releases SDA before the STOP.
- R9: The slave changes its SDA drive only while the synchronised SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R10: div_wr, mux_wr and bus_wr each pulse for one cycle for every data byte stored in their register.
- R11: Reset sets DIV to 0x155, MUX to 0x0AA and BUS to 0x00. Reset releases SDA and clears all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | High pulls the data line low (open drain) |
| div_q | output | 10 | DIV register value |
| mux_q | output | 10 | MUX register value |
| bus_q | output | 8 | BUS register value; bits 2..0 are the device address |
| div_wr | output | 1 | One-cycle pulse per stored DIV byte |
| mux_wr | output | 1 | One-cycle pulse per stored MUX byte |
| bus_wr | output | 1 | One-cycle pulse per stored BUS byte |
| commit_req | output | 1 | One-cycle pulse on a commit command |

## Verification
A sweep of two-byte DIV and MUX values, each written and read back, separates the upper and lower byte paths and catches swapped or misplaced bit fields. A second sweep moves the device address through all eight values. After each move the old address must draw no acknowledge, which shows that address matching follows the BUS register. MSB-only writes, over-long writes and reads, standalone commits and an unknown command each check one part of command decoding: partial update, discard, 0xFF fill, and the commit pulse with no register change. A line monitor confirms that the slave's drive never moves while SCL is high.

// File: rtl/cmdreg_pkg.sv
// Package: shared constants and types for the two-wire command register slave.
// Assumes a 7-bit control field made of a fixed tag and a 3-bit device address.
package cmdreg_pkg;
    localparam int ADDR_W = 3;
    localparam logic [6-ADDR_W:0] CTRL_TAG = 4'b1011;

    // Byte index within a register transfer; the top value means "past the end".
    localparam int IDX_W = 2;
    localparam logic [IDX_W-1:0] IDX_LAST = 2'd2;

    localparam logic [7:0] CMD_DIV    = 8'h01;
    localparam logic [7:0] CMD_MUX    = 8'h02;
    localparam logic [7:0] CMD_BUS    = 8'h0D;
    localparam logic [7:0] CMD_COMMIT = 8'h3F;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_CTRL,
        LK_CMD,
        LK_WDATA,
        LK_RDATA,
        LK_IGNORE
    } link_st_e;
endpackage

// File: rtl/twi_line_sync.sv
// Module: brings SCL and SDA into the clock domain through a flip-flop chain
// and reports clock edges plus START and STOP conditions as one-cycle events.
// Assumes each bus phase lasts several system clocks; there is no glitch filter.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw pad levels (idle bus is high).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_in;
                    sda_ff[g] <= sda_in;
                end
            end
        end else begin : g_next
            // Later stages: pass the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_evt = scl_s & scl_p & sda_p & ~sda_s;
        stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/twi_link_fsm.sv
// Module: bit and byte engine of the slave. Counts SCL pulses, assembles
// received bytes, matches the control byte, drives ACK, and shifts read bytes out.
// Assumes events from twi_line_sync. SDA drive changes only on SCL falling events
// or bus conditions. Reports command and data bytes to the register file.
module twi_link_fsm
    import cmdreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [7:0]       tx_byte,
    output logic             cmd_wr,
    output logic             dat_wr,
    output logic [7:0]       rx_byte,
    output logic [IDX_W-1:0] dat_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_low
);
    link_st_e    state;
    logic [3:0]  bitcnt;      // 0..7 data bits, 8 = ack slot, 9 = after ack sample
    logic [6:0]  shreg;
    logic [7:0]  rx_full;
    logic [6:0]  tx_rest;
    logic        txing;
    logic        ack_pend;
    logic        master_nack;

    // Byte as it stands once the current SDA sample is included.
    assign rx_full = {shreg, sda_s};

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= LK_IDLE;
            bitcnt      <= 4'd0;
            shreg       <= '0;
            tx_rest     <= '0;
            txing       <= 1'b0;
            ack_pend    <= 1'b0;
            master_nack <= 1'b1;
            sda_low     <= 1'b0;
            cmd_wr      <= 1'b0;
            dat_wr      <= 1'b0;
            rx_byte     <= '0;
            dat_idx     <= '0;
            rd_idx      <= '0;
        end else begin
            cmd_wr <= 1'b0;
            dat_wr <= 1'b0;
            if (dat_wr && dat_idx != IDX_LAST) begin
                dat_idx <= dat_idx + 1'b1;
            end
            if (start_evt) begin
                state    <= LK_CTRL;
                bitcnt   <= 4'd0;
                sda_low  <= 1'b0;
                ack_pend <= 1'b0;
                txing    <= 1'b0;
            end else if (stop_evt) begin
                state    <= LK_IDLE;
                bitcnt   <= 4'd0;
                sda_low  <= 1'b0;
                ack_pend <= 1'b0;
                txing    <= 1'b0;
            end else if (state != LK_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        shreg  <= rx_full[6:0];
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            unique case (state)
                                LK_CTRL: begin
                                    if (rx_full[7:1] == {CTRL_TAG, dev_addr}) begin
                                        ack_pend <= 1'b1;
                                        if (rx_full[0]) begin
                                            state  <= LK_RDATA;
                                            rd_idx <= '0;
                                        end else begin
                                            state <= LK_CMD;
                                        end
                                    end else begin
                                        state <= LK_IGNORE;
                                    end
                                end
                                LK_CMD: begin
                                    ack_pend <= 1'b1;
                                    cmd_wr   <= 1'b1;
                                    rx_byte  <= rx_full;
                                    dat_idx  <= '0;
                                    state    <= LK_WDATA;
                                end
                                LK_WDATA: begin
                                    ack_pend <= 1'b1;
                                    dat_wr   <= 1'b1;
                                    rx_byte  <= rx_full;
                                end
                                LK_RDATA: begin
                                    if (rd_idx != IDX_LAST) begin
                                        rd_idx <= rd_idx + 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (bitcnt == 4'd8) begin
                        master_nack <= sda_s;
                        bitcnt      <= 4'd9;
                    end
                end else if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        sda_low  <= ack_pend;
                        ack_pend <= 1'b0;
                        txing    <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        bitcnt  <= 4'd0;
                        sda_low <= 1'b0;
                        if (state == LK_RDATA) begin
                            if (!master_nack) begin
                                tx_rest <= tx_byte[6:0];
                                sda_low <= ~tx_byte[7];
                                txing   <= 1'b1;
                            end else begin
                                state <= LK_IGNORE;
                            end
                        end
                    end else if (txing && bitcnt != 4'd0) begin
                        sda_low <= ~tx_rest[6];
                        tx_rest <= {tx_rest[5:0], 1'b0};
                    end
                end
            end
        end
    end

    // R9: the drive only moves while SCL is low, or on a bus condition.
    a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low != $past(sda_low)) |-> (!$past(scl_s) || $past(start_evt || stop_evt)));

    // R1: an idle or unaddressed slave never pulls the line.
    a_r1_quiet_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_IGNORE || state == LK_IDLE) |-> !sda_low);

    // R2: a received byte is either a command or a data byte, never both.
    a_r2_one_byte_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && dat_wr));

    // R8: the bit counter never leaves its nine-pulse frame.
    a_r8_bit_frame: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd9);
endmodule

// File: rtl/twi_word_reg.sv
// Module: one configuration word of W bits (9..16), exposed as two bytes with
// the value left-aligned: the high byte holds the top 8 bits, and the low byte
// holds the rest in its upper positions, zero-filled below.
// Assumes at most one of wr_hi and wr_lo per cycle.
module twi_word_reg #(
    parameter int          W   = 10,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [7:0]   wdata,
    output logic [W-1:0] q,
    output logic [7:0]   rd_hi,
    output logic [7:0]   rd_lo
);
    localparam int PAD = 16 - W;

    logic [15:0] padded;

    assign padded = 16'(q) << PAD;
    assign rd_hi  = padded[15:8];
    assign rd_lo  = padded[7:0];

    // Value storage: replace the addressed byte of the left-aligned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (wr_hi) begin
            q <= W'({wdata, padded[7:0]} >> PAD);
        end else if (wr_lo) begin
            q <= W'({padded[15:8], wdata} >> PAD);
        end
    end

    // R10: the value changes only in the cycle after a byte write.
    a_r10_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> $past(wr_hi || wr_lo));

    // R4: an upper-byte write leaves the low bits as they were.
    a_r4_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hi) |-> (q[W-9:0] == $past(q[W-9:0])));
endmodule

// File: rtl/cmd_regfile.sv
// Module: holds the latched command and the DIV, MUX and BUS registers. It
// applies data bytes by command and byte index, picks the byte to send on
// reads, and raises the write and commit strobes.
// Assumes cmd_wr and dat_wr are one-cycle pulses from the link engine.
module cmd_regfile
    import cmdreg_pkg::*;
#(
    parameter int              DIV_W   = 10,
    parameter int              MUX_W   = 10,
    parameter logic [DIV_W-1:0] DIV_RST = 10'h155,
    parameter logic [MUX_W-1:0] MUX_RST = 10'h0AA,
    parameter logic [7:0]      BUS_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             dat_wr,
    input  logic [7:0]       rx_byte,
    input  logic [IDX_W-1:0] dat_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       tx_byte,
    output logic [DIV_W-1:0] div_q,
    output logic [MUX_W-1:0] mux_q,
    output logic [7:0]       bus_q,
    output logic             div_wr,
    output logic             mux_wr,
    output logic             bus_wr,
    output logic             commit_req
);
    logic [7:0] cmd_q;
    logic       div_hi_we, div_lo_we, mux_hi_we, mux_lo_we, bus_we;
    logic [7:0] div_hi_b, div_lo_b, mux_hi_b, mux_lo_b;

    // Byte-enable decode from the latched command and the byte index.
    always_comb begin
        div_hi_we = dat_wr && cmd_q == CMD_DIV && dat_idx == 2'd0;
        div_lo_we = dat_wr && cmd_q == CMD_DIV && dat_idx == 2'd1;
        mux_hi_we = dat_wr && cmd_q == CMD_MUX && dat_idx == 2'd0;
        mux_lo_we = dat_wr && cmd_q == CMD_MUX && dat_idx == 2'd1;
        bus_we    = dat_wr && cmd_q == CMD_BUS && dat_idx == 2'd0;
    end

    twi_word_reg #(.W(DIV_W), .RST(DIV_RST)) u_div (
        .clk(clk), .rst_n(rst_n), .wr_hi(div_hi_we), .wr_lo(div_lo_we),
        .wdata(rx_byte), .q(div_q), .rd_hi(div_hi_b), .rd_lo(div_lo_b)
    );

    twi_word_reg #(.W(MUX_W), .RST(MUX_RST)) u_mux (
        .clk(clk), .rst_n(rst_n), .wr_hi(mux_hi_we), .wr_lo(mux_lo_we),
        .wdata(rx_byte), .q(mux_q), .rd_hi(mux_hi_b), .rd_lo(mux_lo_b)
    );

    // Command latch, BUS register and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= 8'h00;
            bus_q      <= BUS_RST;
            div_wr     <= 1'b0;
            mux_wr     <= 1'b0;
            bus_wr     <= 1'b0;
            commit_req <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= rx_byte;
            end
            if (bus_we) begin
                bus_q <= rx_byte;
            end
            div_wr     <= div_hi_we | div_lo_we;
            mux_wr     <= mux_hi_we | mux_lo_we;
            bus_wr     <= bus_we;
            commit_req <= cmd_wr && rx_byte == CMD_COMMIT;
        end
    end

    // Read-byte selection by command and byte index.
    always_comb begin
        tx_byte = FILL_BYTE;
        unique case (cmd_q)
            CMD_DIV: if (rd_idx == 2'd0) tx_byte = div_hi_b;
                     else if (rd_idx == 2'd1) tx_byte = div_lo_b;
            CMD_MUX: if (rd_idx == 2'd0) tx_byte = mux_hi_b;
                     else if (rd_idx == 2'd1) tx_byte = mux_lo_b;
            CMD_BUS: if (rd_idx == 2'd0) tx_byte = bus_q;
            default: ;
        endcase
    end

    // R6: a commit request lasts exactly one cycle.
    a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> !commit_req);

    // R5: the BUS value changes only together with its strobe.
    a_r5_bus_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q != $past(bus_q)) |-> bus_wr);
endmodule

// File: rtl/cmdreg_twi_slave.sv
// Module: top of the two-wire command register slave. It joins the line
// synchroniser, the link engine and the register file. The device address is
// taken from the low bits of the BUS register.
// Assumes an external open-drain pad: a high sda_drive_low pulls SDA low.
module cmdreg_twi_slave
    import cmdreg_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              DIV_W       = 10,
    parameter int              MUX_W       = 10,
    parameter logic [DIV_W-1:0] DIV_RST     = 10'h155,
    parameter logic [MUX_W-1:0] MUX_RST     = 10'h0AA,
    parameter logic [7:0]      BUS_RST     = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic [DIV_W-1:0] div_q,
    output logic [MUX_W-1:0] mux_q,
    output logic [7:0]       bus_q,
    output logic             div_wr,
    output logic             mux_wr,
    output logic             bus_wr,
    output logic             commit_req
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic             cmd_wr, dat_wr;
    logic [7:0]       rx_byte, tx_byte;
    logic [IDX_W-1:0] dat_idx, rd_idx;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_link_fsm u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .dev_addr(bus_q[ADDR_W-1:0]), .tx_byte(tx_byte),
        .cmd_wr(cmd_wr), .dat_wr(dat_wr), .rx_byte(rx_byte),
        .dat_idx(dat_idx), .rd_idx(rd_idx), .sda_low(sda_drive_low)
    );

    cmd_regfile #(
        .DIV_W(DIV_W), .MUX_W(MUX_W),
        .DIV_RST(DIV_RST), .MUX_RST(MUX_RST), .BUS_RST(BUS_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .rx_byte(rx_byte), .dat_idx(dat_idx), .rd_idx(rd_idx),
        .tx_byte(tx_byte), .div_q(div_q), .mux_q(mux_q), .bus_q(bus_q),
        .div_wr(div_wr), .mux_wr(mux_wr), .bus_wr(bus_wr),
        .commit_req(commit_req)
    );
endmodule

// File: tb/cmdreg_twi_slave_bench.sv
// Bench: drives the bus as a master, with bit-level tasks, and checks the
// register values, the acknowledges, the read data and the strobe counts
// against values computed from the requirements.
module cmdreg_twi_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic dut_low;
    wire  sda_line = ~(m_sda_low | dut_low);

    logic [9:0] div_q, mux_q;
    logic [7:0] bus_q;
    logic       div_wr, mux_wr, bus_wr, commit_req;

    cmdreg_twi_slave u_cmdreg_twi_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_drive_low(dut_low), .div_q(div_q), .mux_q(mux_q), .bus_q(bus_q),
        .div_wr(div_wr), .mux_wr(mux_wr), .bus_wr(bus_wr), .commit_req(commit_req)
    );

    int n_chk = 0, n_fail = 0;
    int c_div = 0, c_mux = 0, c_bus = 0, c_com = 0, r9_viol = 0;
    logic prev_low = 1'b0;

    // Strobe counters and SDA-drive monitor (R9, R10).
    always @(posedge clk) begin
        prev_low <= dut_low;
        if (rst_n) begin
            if (div_wr) c_div++;
            if (mux_wr) c_mux++;
            if (bus_wr) c_bus++;
            if (commit_req) c_com++;
            if (dut_low !== prev_low && m_scl) r9_viol++;
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b1; q_wait(); m_scl = 1'b0; q_wait();
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; q_wait(); m_scl = 1'b1; q_wait();
        m_sda_low = 1'b1; q_wait(); m_scl = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
        m_sda_low = 1'b0; q_wait(); q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; q_wait(); m_scl = 1'b1; q_wait(); q_wait();
            m_scl = 1'b0; q_wait();
        end
        m_sda_low = 1'b0; q_wait(); m_scl = 1'b1; q_wait();
        acked = ~sda_line; q_wait(); m_scl = 1'b0; q_wait();
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b, output bit released);
        for (int i = 7; i >= 0; i--) begin
            q_wait(); m_scl = 1'b1; q_wait(); b[i] = sda_line; q_wait(); m_scl = 1'b0;
        end
        m_sda_low = ~last; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0;
        m_sda_low = 1'b0; q_wait();
        released = ~dut_low;
    endtask

    function automatic logic [7:0] ctrl(input logic [2:0] a, input bit rd);
        return {4'b1011, a, rd};
    endfunction

    task automatic write_txn(input logic [2:0] a, input logic [7:0] cmd, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             output int acks);
        bit k;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        acks = 0;
        bus_start();
        send_byte(ctrl(a, 1'b0), k); acks += int'(k);
        send_byte(cmd, k); acks += int'(k);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], k); acks += int'(k);
        end
        bus_stop();
    endtask

    task automatic read_txn(input logic [2:0] a, input logic [7:0] cmd, input int n,
                            output logic [7:0] r0, output logic [7:0] r1, output int acks,
                            output bit released);
        bit k;
        logic [7:0] b;
        acks = 0; r0 = 8'h00; r1 = 8'h00;
        bus_start();
        send_byte(ctrl(a, 1'b0), k); acks += int'(k);
        send_byte(cmd, k); acks += int'(k);
        bus_rstart();
        send_byte(ctrl(a, 1'b1), k); acks += int'(k);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b, released);
            if (i == 0) r0 = b; else r1 = b;
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    function automatic logic [7:0] hi_b(input logic [9:0] v); return v[9:2]; endfunction
    function automatic logic [7:0] lo_b(input logic [9:0] v); return {v[1:0], 6'b0}; endfunction

    initial begin
        int acks, b_div, b_mux, b_bus, b_com;
        bit rel;
        logic [7:0] r0, r1, bval;
        logic [9:0] vd, vm, exp_div, exp_mux;
        logic [2:0] addr, old_addr;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        q_wait();

        // R11: reset state.
        check_eq("R11 div reset", 32'(div_q), 32'h155);
        check_eq("R11 mux reset", 32'(mux_q), 32'h0AA);
        check_eq("R11 bus reset", 32'(bus_q), 32'h00);
        check_eq("R11 sda released", 32'(dut_low), 0);
        exp_div = 10'h155; exp_mux = 10'h0AA; addr = 3'd0;

        // R1: a wrong address is not acknowledged and writes nothing.
        write_txn(3'd5, 8'h01, 2, 8'h12, 8'h40, 8'h00, acks);
        check_eq("R1 no ack on mismatch", 32'(acks), 0);
        check_eq("R1 div untouched", 32'(div_q), 32'(exp_div));
        check_eq("R10 no strobe on mismatch", 32'(c_div), 0);

        // R2 R3 R8 R10: sweep of two-byte writes and reads.
        for (int k = 0; k < 8; k++) begin
            vd = 10'((k * 173 + 5) % 1024);
            vm = 10'((k * 291 + 77) % 1024);
            b_div = c_div; b_mux = c_mux;
            write_txn(addr, 8'h01, 2, hi_b(vd), lo_b(vd), 8'h00, acks);
            check_eq("R2 acks div write", 32'(acks), 4);
            write_txn(addr, 8'h02, 2, hi_b(vm), lo_b(vm), 8'h00, acks);
            check_eq("R2 acks mux write", 32'(acks), 4);
            exp_div = vd; exp_mux = vm;
            check_eq("R3 div value", 32'(div_q), 32'(exp_div));
            check_eq("R3 mux value", 32'(mux_q), 32'(exp_mux));
            check_eq("R10 div strobes", 32'(c_div - b_div), 2);
            check_eq("R10 mux strobes", 32'(c_mux - b_mux), 2);
            read_txn(addr, 8'h01, 2, r0, r1, acks, rel);
            check_eq("R8 div read acks", 32'(acks), 3);
            check_eq("R3 div msb read", 32'(r0), 32'(hi_b(exp_div)));
            check_eq("R3 div lsb read", 32'(r1), 32'(lo_b(exp_div)));
            check_eq("R8 release after nack", 32'(rel), 1);
            read_txn(addr, 8'h02, 2, r0, r1, acks, rel);
            check_eq("R3 mux msb read", 32'(r0), 32'(hi_b(exp_mux)));
            check_eq("R3 mux lsb read", 32'(r1), 32'(lo_b(exp_mux)));
        end

        // R4: MSB-only writes keep the two low bits.
        b_div = c_div;
        write_txn(addr, 8'h01, 1, 8'hA5, 8'h00, 8'h00, acks);
        exp_div = {8'hA5, exp_div[1:0]};
        check_eq("R4 div msb only", 32'(div_q), 32'(exp_div));
        check_eq("R10 single strobe", 32'(c_div - b_div), 1);
        write_txn(addr, 8'h02, 1, 8'h3C, 8'h00, 8'h00, acks);
        exp_mux = {8'h3C, exp_mux[1:0]};
        check_eq("R4 mux msb only", 32'(mux_q), 32'(exp_mux));

        // R5 R7: sweep of device addresses via BUS.
        for (int i = 1; i <= 8; i++) begin
            old_addr = addr;
            addr = 3'(i % 8);
            bval = {addr, 2'b01, addr};
            b_bus = c_bus;
            write_txn(old_addr, 8'h0D, 2, bval, 8'h5A, 8'h00, acks);
            check_eq("R2 acks bus write", 32'(acks), 4);
            check_eq("R5 bus value", 32'(bus_q), 32'(bval));
            check_eq("R10 bus strobe", 32'(c_bus - b_bus), 1);
            write_txn(old_addr, 8'h0D, 1, 8'h00, 8'h00, 8'h00, acks);
            check_eq("R5 old address ignored", 32'(acks), 0);
            check_eq("R5 bus kept", 32'(bus_q), 32'(bval));
            read_txn(addr, 8'h0D, 2, r0, r1, acks, rel);
            check_eq("R5 bus read", 32'(r0), 32'(bval));
            check_eq("R7 past-end read", 32'(r1), 32'hFF);
        end

        // R6: standalone commit pulses once and changes nothing.
        b_com = c_com; b_div = c_div; b_mux = c_mux; b_bus = c_bus;
        write_txn(addr, 8'h3F, 0, 8'h00, 8'h00, 8'h00, acks);
        check_eq("R6 commit acks", 32'(acks), 2);
        check_eq("R6 commit pulse", 32'(c_com - b_com), 1);
        check_eq("R6 div unchanged", 32'(div_q), 32'(exp_div));
        check_eq("R6 no write strobes", 32'((c_div - b_div) + (c_mux - b_mux) + (c_bus - b_bus)), 0);

        // R7: an unknown command is acknowledged, discarded, and reads 0xFF.
        write_txn(addr, 8'h77, 2, 8'h11, 8'h22, 8'h00, acks);
        check_eq("R7 unknown acks", 32'(acks), 4);
        check_eq("R7 div unchanged", 32'(div_q), 32'(exp_div));
        check_eq("R7 mux unchanged", 32'(mux_q), 32'(exp_mux));
        check_eq("R7 bus unchanged", 32'(bus_q), 32'({addr, 2'b01, addr}));
        read_txn(addr, 8'h77, 2, r0, r1, acks, rel);
        check_eq("R7 unknown read0", 32'(r0), 32'hFF);
        check_eq("R7 unknown read1", 32'(r1), 32'hFF);
        check_eq("R6 no commit on unknown", 32'(c_com - b_com), 1);

        // R9: the drive never moved while SCL was high.
        check_eq("R9 drive moves only with SCL low", 32'(r9_viol), 0);

        finish_run();
    end
endmodule